// File: doc/BRIEF.md
# Add/Subtract Immediate Execution Unit with Condition Flags

This unit carries out the add-immediate and subtract-immediate operations of a 64-bit processor datapath. It takes a 32-bit instruction word and the value already read from the source register. It returns the write-back value, the destination register index, a write strobe, a flag-write strobe and the four condition flags. The flags are negative, zero, carry and overflow. The unit computes both operations with a single adder. For subtract, the adder inverts the immediate and sets the carry input.

The operand size follows the instruction's size bit. A narrow (32-bit) operation looks only at the low half of the source. It computes every flag at that width and writes back the result zero-extended to 64 bits. The unsigned 12-bit immediate can be shifted left by 12 places before use. The flags are presented as written only when the instruction asks for them. All outputs are registered, so the unit has a latency of one clock cycle. The unit accepts a new instruction on every cycle.

The adder is split into 32-bit lanes. The carry out of the low lane is the narrow carry flag. The carry out of the top lane is the wide carry flag. The unit has no internal state machine. Each cycle is either idle (the input strobe is low) or issue (the strobe is high). An issue cycle always produces a write on the following cycle.

Top module: `aluimm_unit`

## Requirements
- R1: Instruction bit 30 selects the operation: 0 gives source plus immediate, 1 gives source minus immediate.
- R2: Instruction bits [21:10] hold the unsigned immediate. When bit 22 is 1, the immediate is shifted left by 12 before use; when bit 22 is 0, it is used as is.
- R3: When bit 31 is 1, the operation is 64 bits wide and all 64 source bits take part.
- R4: When bit 31 is 0, only source bits [31:0] take part. The result is computed modulo 2^32 and written back with bits [63:32] equal to zero.
- R5: The flag-write strobe is high on a result cycle only if instruction bit 29 was 1. With bit 29 at 0, the strobe stays low.
- R6: N equals the top bit of the result at the active width. Z is 1 exactly when the result at the active width is zero.
- R7: For add, C is the unsigned carry out of the active width. For subtract, C is 1 when no borrow occurs, that is when source ≥ immediate as unsigned numbers at that width.
- R8: V is 1 when the true signed result of the operation does not fit in the active width, for add and for subtract alike.
- R9: An instruction strobed at one rising edge appears on the outputs after the next rising edge: the write strobe is high and the destination index equals instruction bits [4:0]. A cycle with the input strobe low gives a write strobe that is low one cycle later.
- R10: While reset is active, the write strobe, the flag-write strobe, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Value of the source register |
| src_idx | output | 5 | Source register index (bits [9:5]), combinational, for the register read |
| wr_en | output | 1 | Write the result this cycle |
| rd_idx | output | 5 | Destination register index |
| result | output | 64 | Write-back value |
| flag_we | output | 1 | Update the condition flags this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions assume that the instruction word and the source value are stable and known whenever the input strobe is high. They also assume that the strobe itself is never unknown after reset. They make no assumption about the class bits [28:23], which the unit ignores. The bench changes its inputs only on falling edges and holds them for a full cycle. It covers both widths, both operations and both immediate shifts. Its operands include zero, all-ones, the largest positive value and the most negative value, placed so that carry, borrow and signed overflow each appear at both widths.

// File: rtl/aluimm_pkg.sv
package aluimm_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam int INSTR_W = 32;
    localparam int REG_IDX_W = 5;

    // instruction bit positions decoded by the unit
    localparam int POS_SIZE  = 31;
    localparam int POS_OP    = 30;
    localparam int POS_SETF  = 29;
    localparam int POS_SHIFT = 22;
    localparam int POS_IMM   = 10;
    localparam int POS_RN    = 5;
    localparam int POS_RD    = 0;

endpackage

// File: rtl/aluimm_decode.sv
module aluimm_decode
    import aluimm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 12,
    parameter int IMM_SH = 12
) (
    input  logic [INSTR_W-1:0]   instr,
    output logic                 wide,
    output op_e                  op,
    output logic                 setf,
    output logic [DATA_W-1:0]    imm,
    output logic [REG_IDX_W-1:0] rd,
    output logic [REG_IDX_W-1:0] rn
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [IMM_W-1:0]  imm_raw;
    logic [DATA_W-1:0] imm_ext;
    logic              unused_class_bits;

    assign imm_raw = instr[POS_IMM +: IMM_W];
    assign imm_ext = {{PAD_W{1'b0}}, imm_raw};
    assign unused_class_bits = ^instr[28:23];

    always_comb begin
        wide = instr[POS_SIZE];
        op   = op_e'(instr[POS_OP]);
        setf = instr[POS_SETF];
        rd   = instr[POS_RD +: REG_IDX_W];
        rn   = instr[POS_RN +: REG_IDX_W];
        imm  = instr[POS_SHIFT] ? (imm_ext << IMM_SH) : imm_ext;
    end

    always_comb begin
        assert (instr[POS_SHIFT] || imm[DATA_W-1:IMM_W] == '0); // R2
    end
endmodule

// File: rtl/aluimm_adder.sv
module aluimm_adder #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 32
) (
    input  logic [DATA_W-1:0]          a,
    input  logic [DATA_W-1:0]          b,
    input  logic                       sub,
    output logic [DATA_W-1:0]          sum,
    output logic [DATA_W/LANE_W-1:0]   lane_cout,
    output logic [DATA_W/LANE_W-1:0]   lane_a_msb,
    output logic [DATA_W/LANE_W-1:0]   lane_bx_msb
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES:0] carry;
    assign carry[0] = sub;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] bx_l;
        assign a_l  = a[g*LANE_W +: LANE_W];
        assign bx_l = b[g*LANE_W +: LANE_W] ^ {LANE_W{sub}};
        assign {carry[g+1], sum[g*LANE_W +: LANE_W]} =
            {1'b0, a_l} + {1'b0, bx_l} + {{LANE_W{1'b0}}, carry[g]};
        assign lane_a_msb[g]  = a_l[LANE_W-1];
        assign lane_bx_msb[g] = bx_l[LANE_W-1];
    end

    assign lane_cout = carry[LANES:1];
endmodule

// File: rtl/aluimm_flags.sv
module aluimm_flags #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 32
) (
    input  logic [DATA_W-1:0]        sum,
    input  logic [DATA_W/LANE_W-1:0] lane_cout,
    input  logic [DATA_W/LANE_W-1:0] lane_a_msb,
    input  logic [DATA_W/LANE_W-1:0] lane_bx_msb,
    input  logic                     wide,
    output logic                     n,
    output logic                     z,
    output logic                     c,
    output logic                     v
);
    localparam int LANES = DATA_W / LANE_W;

    logic a_top, bx_top, r_top;

    always_comb begin
        if (wide) begin
            a_top  = lane_a_msb[LANES-1];
            bx_top = lane_bx_msb[LANES-1];
            r_top  = sum[DATA_W-1];
            c      = lane_cout[LANES-1];
            z      = (sum == '0);
        end else begin
            a_top  = lane_a_msb[0];
            bx_top = lane_bx_msb[0];
            r_top  = sum[LANE_W-1];
            c      = lane_cout[0];
            z      = (sum[LANE_W-1:0] == '0);
        end
        n = r_top;
        // same-sign operands producing an opposite-sign result
        v = (a_top == bx_top) && (r_top != a_top);
    end
endmodule

// File: rtl/aluimm_unit.sv
module aluimm_unit
    import aluimm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 32,
    parameter int IMM_W  = 12,
    parameter int IMM_SH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [63:0]       src_val,
    output logic [4:0]        src_idx,
    output logic              wr_en,
    output logic [4:0]        rd_idx,
    output logic [63:0]       result,
    output logic              flag_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HIGH_W = DATA_W - LANE_W;

    logic              d_wide;
    op_e               d_op;
    logic              d_setf;
    logic [DATA_W-1:0] d_imm;
    logic [4:0]        d_rd;

    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] res_next;
    logic [LANES-1:0]  lane_cout, lane_a_msb, lane_bx_msb;
    logic              n_next, z_next, c_next, v_next;
    logic              wide_q;

    aluimm_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IMM_SH(IMM_SH)) u_dec (
        .instr (instr),
        .wide  (d_wide),
        .op    (d_op),
        .setf  (d_setf),
        .imm   (d_imm),
        .rd    (d_rd),
        .rn    (src_idx)
    );

    assign a_eff = d_wide ? src_val : {{HIGH_W{1'b0}}, src_val[LANE_W-1:0]};

    aluimm_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_add (
        .a           (a_eff),
        .b           (d_imm),
        .sub         (d_op == OP_SUB),
        .sum         (sum),
        .lane_cout   (lane_cout),
        .lane_a_msb  (lane_a_msb),
        .lane_bx_msb (lane_bx_msb)
    );

    aluimm_flags #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_flg (
        .sum         (sum),
        .lane_cout   (lane_cout),
        .lane_a_msb  (lane_a_msb),
        .lane_bx_msb (lane_bx_msb),
        .wide        (d_wide),
        .n           (n_next),
        .z           (z_next),
        .c           (c_next),
        .v           (v_next)
    );

    assign res_next = d_wide ? sum : {{HIGH_W{1'b0}}, sum[LANE_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            flag_we <= 1'b0;
            rd_idx  <= '0;
            result  <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_c  <= 1'b0;
            flag_v  <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            wr_en   <= in_valid;
            flag_we <= in_valid && d_setf;
            if (in_valid) begin
                rd_idx <= d_rd;
                result <= res_next;
                flag_n <= n_next;
                flag_z <= z_next;
                flag_c <= c_next;
                flag_v <= v_next;
                wide_q <= d_wide;
            end
        end
    end

    AST_WR_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> wr_en); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !wr_en); // R9
    AST_FLAG_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> wr_en); // R5
    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wide_q) |-> (result[63:32] == '0)); // R4
    AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (flag_we && wide_q) |-> (flag_z == (result == '0))); // R6
    AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> (flag_n == (wide_q ? result[63] : result[31]))); // R6
endmodule

// File: tb/sim_aluimm_unit.sv
module sim_aluimm_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic [4:0]  src_idx;
    logic        wr_en;
    logic [4:0]  rd_idx;
    logic [63:0] result;
    logic        flag_we, flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [63:0] res;
        logic [4:0]  rd;
        logic        fwe;
        logic [3:0]  nzcv;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    aluimm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .src_idx(src_idx), .wr_en(wr_en), .rd_idx(rd_idx),
        .result(result), .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic logic [31:0] mk(input logic sf, input logic sub, input logic s,
                                       input logic sh, input logic [11:0] imm,
                                       input logic [4:0] rd);
        return {sf, sub, s, 6'b100010, sh, imm, 5'd3, rd};
    endfunction

    function automatic exp_t model(input logic [31:0] ins, input logic [63:0] src, input string tag);
        exp_t e;
        logic [63:0] imm;
        logic [64:0] u;
        logic signed [65:0] sr;
        imm = {52'b0, ins[21:10]};
        if (ins[22]) imm = imm << 12;
        e.tag = tag;
        e.rd  = ins[4:0];
        e.fwe = ins[29];
        if (ins[31]) begin
            u  = ins[30] ? ({1'b0, src} - {1'b0, imm}) : ({1'b0, src} + {1'b0, imm});
            sr = ins[30] ? ($signed({{2{src[63]}}, src}) - $signed({2'b00, imm}))
                         : ($signed({{2{src[63]}}, src}) + $signed({2'b00, imm}));
            e.res = u[63:0];
            e.nzcv[3] = u[63];
            e.nzcv[2] = (u[63:0] == 64'd0);
            e.nzcv[1] = ins[30] ? (src >= imm) : u[64];
            e.nzcv[0] = (sr[64] != sr[63]);
        end else begin
            logic [32:0] uw;
            logic signed [33:0] sw;
            uw = ins[30] ? ({1'b0, src[31:0]} - {1'b0, imm[31:0]}) : ({1'b0, src[31:0]} + {1'b0, imm[31:0]});
            sw = ins[30] ? ($signed({{2{src[31]}}, src[31:0]}) - $signed({2'b00, imm[31:0]}))
                         : ($signed({{2{src[31]}}, src[31:0]}) + $signed({2'b00, imm[31:0]}));
            e.res = {32'd0, uw[31:0]};
            e.nzcv[3] = uw[31];
            e.nzcv[2] = (uw[31:0] == 32'd0);
            e.nzcv[1] = ins[30] ? (src[31:0] >= imm[31:0]) : uw[32];
            e.nzcv[0] = (sw[32] != sw[31]);
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] ins, input logic [63:0] src, input string tag);
        @(negedge clk);
        instr    = ins;
        src_val  = src;
        in_valid = 1'b1;
        sb.push_back(model(ins, src, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr    = 32'hFFFF_FFFF;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected write, actual wr_en=1 expected 0");
            end else begin
                exp_t e;
                logic ok;
                e = sb.pop_front();
                ok = (result == e.res) && (rd_idx == e.rd) && (flag_we == e.fwe);
                if (e.fwe) ok = ok && ({flag_n, flag_z, flag_c, flag_v} == e.nzcv);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s: actual res=%h rd=%0d fwe=%b nzcv=%b expected res=%h rd=%0d fwe=%b nzcv=%b",
                             e.tag, result, rd_idx, flag_we, {flag_n, flag_z, flag_c, flag_v},
                             e.res, e.rd, e.fwe, e.nzcv);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 5000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        checks++;
        if ({wr_en, flag_we, flag_n, flag_z, flag_c, flag_v} != 6'b0 || result != 64'd0) begin
            fails++;
            $display("FAIL R10: actual wr=%b fwe=%b nzcv=%b res=%h expected all zero",
                     wr_en, flag_we, {flag_n, flag_z, flag_c, flag_v}, result);
        end
        rst_n = 1'b1;
        idle(2);

        send(mk(1, 0, 1, 0, 12'd5, 5'd1), 64'd100, "R1 add");
        send(mk(1, 1, 1, 0, 12'd5, 5'd2), 64'd100, "R1 sub");
        send(mk(1, 0, 1, 1, 12'h123, 5'd4), 64'd0, "R2 shifted imm");
        send(mk(1, 1, 1, 1, 12'hFFF, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, "R2 shifted sub all-ones");
        send(mk(1, 0, 1, 0, 12'd1, 5'd6), 64'h0000_0000_FFFF_FFFF, "R3 carry into upper half");
        send(mk(1, 0, 1, 0, 12'd1, 5'd7), 64'hFFFF_FFFF_FFFF_FFFF, "R3 wide wrap carry");
        send(mk(0, 0, 1, 0, 12'd1, 5'd8), 64'hDEAD_BEEF_FFFF_FFFF, "R4 narrow wrap");
        send(mk(0, 1, 1, 0, 12'd2, 5'd9), 64'h1234_5678_0000_0001, "R4 narrow sub borrow");
        send(mk(1, 0, 0, 0, 12'd9, 5'd10), 64'd7, "R5 no flag write");
        send(mk(0, 1, 0, 1, 12'd1, 5'd11), 64'd0, "R5 narrow no flag write");
        send(mk(1, 1, 1, 0, 12'd1, 5'd12), 64'd0, "R6 negative");
        send(mk(1, 1, 1, 0, 12'd77, 5'd13), 64'd77, "R6 R7 equal sub zero no-borrow");
        send(mk(0, 1, 1, 0, 12'd1, 5'd14), 64'hFFFF_FFFF_0000_0000, "R7 narrow borrow");
        send(mk(1, 0, 1, 0, 12'd1, 5'd15), 64'h7FFF_FFFF_FFFF_FFFF, "R8 wide add overflow");
        send(mk(1, 1, 1, 0, 12'd1, 5'd16), 64'h8000_0000_0000_0000, "R8 wide sub overflow");
        send(mk(0, 0, 1, 0, 12'd1, 5'd17), 64'h0000_0000_7FFF_FFFF, "R8 narrow add overflow");
        send(mk(0, 1, 1, 0, 12'd1, 5'd18), 64'h0000_0000_8000_0000, "R8 narrow sub overflow");
        send(mk(0, 0, 1, 1, 12'hFFF, 5'd19), 64'h0000_0000_7FFF_FFFF, "R8 R2 narrow shifted overflow");
        idle(1);
        send(mk(1, 0, 1, 0, 12'd0, 5'd31), 64'd0, "R9 rd 31 after gap");
        idle(3);

        // R9: idle cycles give no write, and every issue was answered
        checks++;
        if (wr_en !== 1'b0 || sb.size() != 0) begin
            fails++;
            $display("FAIL R9: actual wr_en=%b pending=%0d expected wr_en=0 pending=0", wr_en, sb.size());
        end
        summary();
        $finish;
    end
endmodule